// File: doc/BRIEF.md
# Split-Queue Transaction Ordering Arbiter

This block holds outgoing transactions in three class queues (posted requests, non-posted requests and completions) and decides which queue head leaves next on a single output port. Each arriving entry gets a small wrapping arrival tag. When every head can reach its downstream buffer, the arbiter sends the oldest head, so traffic leaves in arrival order across all three classes. Each class has a downstream credit-available input. A low credit means that class's destination buffer is full, and its head cannot be sent.

When the oldest head is stuck, a younger head may overtake it. Whether it may depends on the pair of classes involved and on the relaxed-ordering flag of the younger entry. Round-robin and fixed class priority play no part. Within a class the queue stays strictly first-in first-out, and only queue heads are ever considered. Upstream logic writes entries through one ready/valid port per class. A downstream stage takes entries through a valid/ready output that carries the class code, the relaxed-ordering flag and the payload word.

Top module: `txn_order_arb`

## Requirements
- R1: After reset, every queue is empty, `out_valid` is low and all three bits of `in_ready` are high.
- R2: When every class with a waiting head has its credit bit high, entries leave in the order they were accepted, across all classes.
- R3: Entries accepted in the same cycle are ordered posted first, then non-posted, then completion. Class index 0 is posted, 1 is non-posted and 2 is completion, both for the bit position in every per-class vector and for the `out_class` code.
- R4: A head whose class credit bit is low is never presented. When no head may go, `out_valid` stays low.
- R5: A posted head may overtake an older non-posted head or an older completion head that cannot go.
- R6: Each class queue is first-in first-out. A posted entry never leaves ahead of an older posted entry, whatever its relaxed-ordering flag.
- R7: A completion head may overtake an older non-posted head that cannot go, whatever its own relaxed-ordering flag.
- R8: A completion head may overtake an older posted head that cannot go only when the completion's relaxed-ordering flag is 1.
- R9: A non-posted head never leaves ahead of an older posted head or an older non-posted entry.
- R10: A non-posted head may overtake an older completion head that cannot go only when the non-posted entry's relaxed-ordering flag is 1.
- R11: A head that cannot go counts as blocked, whether its credit is low or it is held back by an ordering rule. Among the heads allowed to go, the oldest is presented.
- R12: At most 8 entries are held in total, and at most 4 per class. `in_ready[c]` is low when queue c is full, or when accepting it after the lower-indexed classes accepted in the same cycle would exceed the total limit.
- R13: An entry leaves only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low and the credits are unchanged, the presented entry stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Per-class write request (bit 0 posted, 1 non-posted, 2 completion) |
| in_ready | output | 3 | Per-class write accept |
| in_ro | input | 3 | Per-class relaxed-ordering flag of the entry being written |
| in_data | input | 3*DATA_W | Per-class payload word, class c at bits [c*DATA_W +: DATA_W] |
| credit_ok | input | 3 | Per-class downstream buffer has room |
| out_valid | output | 1 | An entry is presented |
| out_ready | input | 1 | Downstream takes the presented entry |
| out_class | output | 2 | Class code of the presented entry |
| out_ro | output | 1 | Relaxed-ordering flag of the presented entry |
| out_data | output | DATA_W | Payload word of the presented entry |

## Verification
The bench builds small mixes of heads and holds one class's credit low. For each pair of classes, and for each value of the relaxed-ordering flag, it checks that the overtaking entry is exactly the one the rules allow. A design that treated the flag as irrelevant would let a plain completion overtake a posted write, or hold back a flagged read behind a completion. The bench also covers an ordering-blocked head sitting between a credit-blocked head and a younger head. A picker that looked only at credits would stall there, or would let a non-posted entry slip ahead. Further runs fill the queues to the per-class and total limits, including three writes in one cycle. These would catch a wrong class order for same-cycle tags, a total count that overflows, or tags that compare wrongly after they wrap.

// File: rtl/txn_arb_pkg.sv
`timescale 1ns/1ps
package txn_arb_pkg;

    localparam int NUM_CLS = 3;

    localparam logic [1:0] CLS_POST = 2'd0;
    localparam logic [1:0] CLS_NONP = 2'd1;
    localparam logic [1:0] CLS_CMPL = 2'd2;

    // May a head of class 'mine' leave before an older blocked head of class 'elder'?
    function automatic logic may_overtake(input logic [1:0] mine,
                                          input logic       mine_ro,
                                          input logic [1:0] elder);
        logic ok;
        ok = 1'b0;
        case (mine)
            CLS_POST: ok = (elder != CLS_POST);
            CLS_CMPL: ok = (elder == CLS_NONP) || ((elder == CLS_POST) && mine_ro);
            CLS_NONP: ok = (elder == CLS_CMPL) && mine_ro;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/txn_arb_fifo.sv
`timescale 1ns/1ps
module txn_arb_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = step(st_q.wr);
        end
        if (pop) begin
            st_d.rd = step(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = st_q.mem[st_q.rd];
    assign not_empty = (st_q.cnt != '0);
    assign full      = (st_q.cnt == CNT_W'(DEPTH));

    a_r12_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);

endmodule

// File: rtl/txn_arb_admit.sv
`timescale 1ns/1ps
module txn_arb_admit
    import txn_arb_pkg::*;
#(
    parameter int SEQ_W        = 4,
    parameter int MAX_INFLIGHT = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CLS-1:0]              in_valid,
    input  logic [NUM_CLS-1:0]              q_full,
    input  logic                            retire,
    output logic [NUM_CLS-1:0]              in_ready,
    output logic [NUM_CLS-1:0]              push,
    output logic [NUM_CLS-1:0][SEQ_W-1:0]   tag
);
    localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [CNT_W-1:0] cnt;
    } admit_st_t;

    admit_st_t st_q, st_d;

    // Classes are admitted in index order so same-cycle tags ascend P, NP, CPL.
    always_comb begin
        int taken;
        taken = 0;
        for (int c = 0; c < NUM_CLS; c++) begin
            in_ready[c] = !q_full[c] && ((int'(st_q.cnt) + taken) < MAX_INFLIGHT);
            tag[c]      = st_q.seq + SEQ_W'(taken);
            push[c]     = in_valid[c] && in_ready[c];
            if (push[c]) begin
                taken = taken + 1;
            end
        end
        st_d.seq = st_q.seq + SEQ_W'(taken);
        st_d.cnt = CNT_W'(int'(st_q.cnt) + taken - (retire ? 1 : 0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r12_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_INFLIGHT));
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (st_q.cnt != '0));

endmodule

// File: rtl/txn_arb_pick.sv
`timescale 1ns/1ps
module txn_arb_pick
    import txn_arb_pkg::*;
#(
    parameter int SEQ_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CLS-1:0]              head_vld,
    input  logic [NUM_CLS-1:0][SEQ_W-1:0]   head_seq,
    input  logic [NUM_CLS-1:0]              head_ro,
    input  logic [NUM_CLS-1:0]              credit,
    output logic                            grant_vld,
    output logic [NUM_CLS-1:0]              grant
);
    localparam logic [SEQ_W-1:0] HALF = SEQ_W'(1) << (SEQ_W - 1);

    // older[i][j]: head j arrived before head i
    logic [NUM_CLS-1:0][NUM_CLS-1:0] older;
    logic [NUM_CLS-1:0]              older_any;
    logic [NUM_CLS-1:0]              elig;

    always_comb begin
        logic [SEQ_W-1:0] gap;
        for (int i = 0; i < NUM_CLS; i++) begin
            for (int j = 0; j < NUM_CLS; j++) begin
                gap         = head_seq[i] - head_seq[j];
                older[i][j] = (i != j) && head_vld[i] && head_vld[j]
                              && (gap != '0) && (gap < HALF);
            end
            older_any[i] = |older[i];
        end
    end

    // Heads are settled in age order: a head goes only if every older head is
    // itself unable to go and the class-pair rule lets it overtake that head.
    always_comb begin
        logic ok;
        ok   = 1'b0;
        elig = '0;
        for (int r = 0; r < NUM_CLS; r++) begin
            for (int i = 0; i < NUM_CLS; i++) begin
                if (head_vld[i] && ($countones(older[i]) == r)) begin
                    ok = credit[i];
                    for (int j = 0; j < NUM_CLS; j++) begin
                        if (older[i][j]) begin
                            ok = ok && !elig[j] && may_overtake(2'(i), head_ro[i], 2'(j));
                        end
                    end
                    elig[i] = ok;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CLS; i++) begin
            grant[i] = elig[i] && ((older[i] & elig) == '0);
        end
        grant_vld = |grant;
    end

    a_r2_age_order: assert property (@(posedge clk) disable iff (!rst_n)
        (((credit | ~head_vld) == '1) && grant_vld) |-> ((grant & older_any) == '0));
    a_r9_np_after_posted: assert property (@(posedge clk) disable iff (!rst_n)
        grant[CLS_NONP] |-> !older[CLS_NONP][CLS_POST]);
    a_r8_cmpl_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[CLS_CMPL] && older[CLS_CMPL][CLS_POST]) |-> head_ro[CLS_CMPL]);
    a_r10_np_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[CLS_NONP] && older[CLS_NONP][CLS_CMPL]) |-> head_ro[CLS_NONP]);
    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: rtl/txn_order_arb.sv
`timescale 1ns/1ps
module txn_order_arb
    import txn_arb_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SEQ_W        = 4,
    parameter int FIFO_DEPTH   = 4,
    parameter int MAX_INFLIGHT = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                in_valid,
    output logic [2:0]                in_ready,
    input  logic [2:0]                in_ro,
    input  logic [3*DATA_W-1:0]       in_data,
    input  logic [2:0]                credit_ok,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [1:0]                out_class,
    output logic                      out_ro,
    output logic [DATA_W-1:0]         out_data
);
    localparam int ENT_W = SEQ_W + 1 + DATA_W;

    logic [NUM_CLS-1:0]              q_full;
    logic [NUM_CLS-1:0]              q_ne;
    logic [NUM_CLS-1:0]              push;
    logic [NUM_CLS-1:0]              pop;
    logic [NUM_CLS-1:0][SEQ_W-1:0]   tag;
    logic [NUM_CLS-1:0][ENT_W-1:0]   head_ent;
    logic [NUM_CLS-1:0][SEQ_W-1:0]   head_seq;
    logic [NUM_CLS-1:0]              head_ro;
    logic [NUM_CLS-1:0]              grant;
    logic                            grant_vld;
    logic                            retire;

    assign retire = out_valid && out_ready;

    txn_arb_admit #(
        .SEQ_W        (SEQ_W),
        .MAX_INFLIGHT (MAX_INFLIGHT)
    ) u_admit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .q_full   (q_full),
        .retire   (retire),
        .in_ready (in_ready),
        .push     (push),
        .tag      (tag)
    );

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
        txn_arb_fifo #(
            .DEPTH (FIFO_DEPTH),
            .W     (ENT_W)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[g]),
            .pop       (pop[g]),
            .din       ({tag[g], in_ro[g], in_data[g*DATA_W +: DATA_W]}),
            .dout      (head_ent[g]),
            .not_empty (q_ne[g]),
            .full      (q_full[g])
        );
        assign head_seq[g] = head_ent[g][ENT_W-1 -: SEQ_W];
        assign head_ro[g]  = head_ent[g][DATA_W];
        assign pop[g]      = grant[g] && out_ready;
    end

    txn_arb_pick #(
        .SEQ_W (SEQ_W)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_vld  (q_ne),
        .head_seq  (head_seq),
        .head_ro   (head_ro),
        .credit    (credit_ok),
        .grant_vld (grant_vld),
        .grant     (grant)
    );

    always_comb begin
        out_valid = grant_vld;
        out_class = '0;
        out_ro    = 1'b0;
        out_data  = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (grant[c]) begin
                out_class = 2'(c);
                out_ro    = head_ro[c];
                out_data  = head_ent[c][DATA_W-1:0];
            end
        end
    end

    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && (in_ready == 3'b111)));
    a_r4_credit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> credit_ok[out_class]);
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid && !out_ready) && $stable(credit_ok))
        |-> (out_valid && $stable(out_data) && $stable(out_class)));

endmodule

// File: tb/sim_txn_order_arb.sv
`timescale 1ns/1ps
module sim_txn_order_arb;

    localparam int CYCLE_LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  in_valid;
    logic [2:0]  in_ready;
    logic [2:0]  in_ro;
    logic [23:0] in_data;
    logic [2:0]  credit_ok;
    logic        out_valid;
    logic        out_ready;
    logic [1:0]  out_class;
    logic        out_ro;
    logic [7:0]  out_data;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_d[$];
    logic [1:0] exp_c[$];
    string      exp_r[$];

    always #5 clk = ~clk;

    txn_order_arb u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_ro     (in_ro),
        .in_data   (in_data),
        .credit_ok (credit_ok),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_class (out_class),
        .out_ro    (out_ro),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic expect_out(input logic [1:0] c, input logic [7:0] d, input string r);
        exp_c.push_back(c);
        exp_d.push_back(d);
        exp_r.push_back(r);
    endtask

    // Monitor: compares every handshake with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n === 1'b1 && out_valid === 1'b1 && out_ready === 1'b1) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, "scoreboard", "unexpected output {class,data}",
                        {out_class, out_data}, 0);
                end else begin
                    logic [7:0] d;
                    logic [1:0] c;
                    string      r;
                    d = exp_d.pop_front();
                    c = exp_c.pop_front();
                    r = exp_r.pop_front();
                    chk(out_data === d && out_class === c, r, "output {class,data}",
                        {out_class, out_data}, {c, d});
                end
            end
        end
    end

    task automatic enq(input int c, input bit ro, input logic [7:0] d,
                       input bit acc, input string r);
        @(negedge clk);
        in_valid[c]        = 1'b1;
        in_ro[c]           = ro;
        in_data[c*8 +: 8]  = d;
        #1;
        chk(in_ready[c] === acc, r, "in_ready on write", in_ready[c], acc);
        @(posedge clk);
        #1;
        in_valid[c] = 1'b0;
    endtask

    task automatic enq3(input logic [2:0] ro, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input logic [2:0] rdy, input string r);
        @(negedge clk);
        in_valid = 3'b111;
        in_ro    = ro;
        in_data  = {d2, d1, d0};
        #1;
        chk(in_ready === rdy, r, "in_ready on triple write", in_ready, rdy);
        @(posedge clk);
        #1;
        in_valid = 3'b000;
    endtask

    task automatic drain(input logic [2:0] cr, input int n, input string r);
        @(negedge clk);
        credit_ok = cr;
        out_ready = 1'b1;
        repeat (n) @(negedge clk);
        out_ready = 1'b0;
        #4;
        chk(exp_d.size() == 0, r, "expected entries left", exp_d.size(), 0);
    endtask

    task automatic chk_idle(input string r);
        @(negedge clk);
        #3;
        chk(out_valid === 1'b0, r, "out_valid while nothing may go", out_valid, 0);
    endtask

    initial begin
        #(CYCLE_LIMIT * 10);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 3'b000;
        in_ro     = 3'b000;
        in_data   = '0;
        credit_ok = 3'b111;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready === 3'b111, "R1", "in_ready after reset", in_ready, 3'b111);

        // R2: mixed arrivals, all credits, arrival order kept
        enq(0, 0, 8'h01, 1, "R2");
        enq(1, 0, 8'h02, 1, "R2");
        enq(2, 0, 8'h03, 1, "R2");
        enq(0, 1, 8'h04, 1, "R2");
        enq(2, 0, 8'h05, 1, "R2");
        enq(1, 1, 8'h06, 1, "R2");
        expect_out(2'd0, 8'h01, "R2"); expect_out(2'd1, 8'h02, "R2");
        expect_out(2'd2, 8'h03, "R2"); expect_out(2'd0, 8'h04, "R2");
        expect_out(2'd2, 8'h05, "R2"); expect_out(2'd1, 8'h06, "R2");
        drain(3'b111, 8, "R2");

        // R3: same-cycle writes after an older completion
        enq(2, 0, 8'h14, 1, "R3");
        enq3(3'b000, 8'h10, 8'h11, 8'h12, 3'b111, "R3");
        expect_out(2'd2, 8'h14, "R3"); expect_out(2'd0, 8'h10, "R3");
        expect_out(2'd1, 8'h11, "R3"); expect_out(2'd2, 8'h12, "R3");
        drain(3'b111, 6, "R3");

        // R4: credit low holds the only head
        enq(1, 0, 8'h20, 1, "R4");
        drain(3'b101, 3, "R4");
        chk_idle("R4");
        expect_out(2'd1, 8'h20, "R4");
        drain(3'b111, 3, "R4");

        // R13: held output while out_ready low
        enq(0, 0, 8'h70, 1, "R13");
        enq(2, 0, 8'h71, 1, "R13");
        @(negedge clk); #3;
        chk(out_valid === 1'b1 && out_data === 8'h70, "R13", "presented data",
            out_data, 8'h70);
        repeat (3) @(negedge clk);
        #3;
        chk(out_valid === 1'b1 && out_data === 8'h70, "R13", "held data",
            out_data, 8'h70);
        expect_out(2'd0, 8'h70, "R13"); expect_out(2'd2, 8'h71, "R13");
        drain(3'b111, 4, "R13");

        // R5: posted passes blocked NP and CPL
        enq(1, 0, 8'h30, 1, "R5");
        enq(2, 0, 8'h31, 1, "R5");
        enq(0, 0, 8'h32, 1, "R5");
        expect_out(2'd0, 8'h32, "R5");
        drain(3'b001, 3, "R5");
        chk_idle("R5");
        expect_out(2'd1, 8'h30, "R5"); expect_out(2'd2, 8'h31, "R5");
        drain(3'b111, 4, "R5");

        // R6: posted stays FIFO while passing a blocked completion
        enq(2, 0, 8'h42, 1, "R6");
        enq(0, 1, 8'h40, 1, "R6");
        enq(0, 1, 8'h41, 1, "R6");
        expect_out(2'd0, 8'h40, "R6"); expect_out(2'd0, 8'h41, "R6");
        drain(3'b011, 4, "R6");
        expect_out(2'd2, 8'h42, "R6");
        drain(3'b111, 3, "R6");

        // R7: completion without RO passes blocked NP
        enq(1, 0, 8'h50, 1, "R7");
        enq(2, 0, 8'h51, 1, "R7");
        expect_out(2'd2, 8'h51, "R7");
        drain(3'b101, 3, "R7");
        expect_out(2'd1, 8'h50, "R7");
        drain(3'b111, 3, "R7");

        // R8: completion vs blocked posted, RO 0 then RO 1
        enq(0, 0, 8'h52, 1, "R8");
        enq(2, 0, 8'h53, 1, "R8");
        drain(3'b110, 3, "R8");
        chk_idle("R8");
        expect_out(2'd0, 8'h52, "R8"); expect_out(2'd2, 8'h53, "R8");
        drain(3'b111, 4, "R8");
        enq(0, 0, 8'h54, 1, "R8");
        enq(2, 1, 8'h55, 1, "R8");
        expect_out(2'd2, 8'h55, "R8");
        drain(3'b110, 3, "R8");
        expect_out(2'd0, 8'h54, "R8");
        drain(3'b111, 3, "R8");

        // R9: NP with RO still waits behind posted
        enq(0, 0, 8'h56, 1, "R9");
        enq(1, 1, 8'h57, 1, "R9");
        drain(3'b110, 3, "R9");
        chk_idle("R9");
        expect_out(2'd0, 8'h56, "R9"); expect_out(2'd1, 8'h57, "R9");
        drain(3'b111, 4, "R9");

        // R10: NP vs blocked completion, RO 0 then RO 1
        enq(2, 0, 8'h58, 1, "R10");
        enq(1, 0, 8'h59, 1, "R10");
        drain(3'b011, 3, "R10");
        chk_idle("R10");
        expect_out(2'd2, 8'h58, "R10"); expect_out(2'd1, 8'h59, "R10");
        drain(3'b111, 4, "R10");
        enq(2, 0, 8'h5A, 1, "R10");
        enq(1, 1, 8'h5B, 1, "R10");
        expect_out(2'd1, 8'h5B, "R10");
        drain(3'b011, 3, "R10");
        expect_out(2'd2, 8'h5A, "R10");
        drain(3'b111, 3, "R10");

        // R11: ordering-blocked NP between blocked posted and RO completion
        enq(0, 0, 8'h60, 1, "R11");
        enq(1, 0, 8'h61, 1, "R11");
        enq(2, 1, 8'h62, 1, "R11");
        expect_out(2'd2, 8'h62, "R11");
        drain(3'b110, 3, "R11");
        chk_idle("R11");
        expect_out(2'd0, 8'h60, "R11"); expect_out(2'd1, 8'h61, "R11");
        drain(3'b111, 4, "R11");
        // R11: two heads may pass a blocked NP, oldest first
        enq(1, 0, 8'h63, 1, "R11");
        enq(0, 0, 8'h64, 1, "R11");
        enq(2, 0, 8'h65, 1, "R11");
        expect_out(2'd0, 8'h64, "R11"); expect_out(2'd2, 8'h65, "R11");
        drain(3'b101, 4, "R11");
        expect_out(2'd1, 8'h63, "R11");
        drain(3'b111, 3, "R11");

        // R12: per-class depth and total limit
        for (int k = 0; k < 4; k++) enq(0, 0, 8'h80 + 8'(k), 1, "R12");
        enq(0, 0, 8'h84, 0, "R12");
        for (int k = 0; k < 4; k++) enq(1, 0, 8'h85 + 8'(k), 1, "R12");
        enq(2, 0, 8'h89, 0, "R12");
        #1;
        chk(in_ready === 3'b000, "R12", "in_ready at total limit", in_ready, 0);
        for (int k = 0; k < 4; k++) expect_out(2'd0, 8'h80 + 8'(k), "R12");
        for (int k = 0; k < 4; k++) expect_out(2'd1, 8'h85 + 8'(k), "R12");
        drain(3'b111, 10, "R12");
        enq(2, 0, 8'h8A, 1, "R12");
        expect_out(2'd2, 8'h8A, "R12");
        drain(3'b111, 3, "R12");
        // R12: triple write with room for two
        for (int k = 0; k < 3; k++) enq(0, 0, 8'h90 + 8'(k), 1, "R12");
        for (int k = 0; k < 3; k++) enq(1, 0, 8'h93 + 8'(k), 1, "R12");
        enq3(3'b000, 8'h96, 8'h97, 8'h98, 3'b011, "R12");
        for (int k = 0; k < 3; k++) expect_out(2'd0, 8'h90 + 8'(k), "R12");
        for (int k = 0; k < 3; k++) expect_out(2'd1, 8'h93 + 8'(k), "R12");
        expect_out(2'd0, 8'h96, "R12"); expect_out(2'd1, 8'h97, "R12");
        drain(3'b111, 10, "R12");

        // R1: reset in mid-run empties the queues
        enq(0, 0, 8'hA0, 1, "R1");
        enq(2, 0, 8'hA1, 1, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #3;
        chk(out_valid === 1'b0, "R1", "out_valid after mid-run reset", out_valid, 0);
        chk(in_ready === 3'b111, "R1", "in_ready after mid-run reset", in_ready, 3'b111);
        drain(3'b111, 3, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule